// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages the page pool of a network controller's packet buffer. The pool holds a fixed number of packet pages (four by default). The host drives a 16-bit command port with encoded commands. One command grants a transmit page. Another returns the whole unit to its initial state. A third discards the entry at the front of the receive queue.

A granted page number appears in an allocation-result byte, and the grant raises an interrupt flag that stays set until the host acknowledges it. The block reports two status words, both built from its own state:

- A memory-information word that packs the free-page count and the total page count.
- A FIFO-ports word that shows the head and the empty flag of two packet-number queues: receive and transmit-completion.

Each queue is filled by a simple valid-plus-number push from the datapath side.

Top module: `pktPageMmu`

## Requirements
- R1: A command write of 0x0020 while at least one page is free marks the lowest-numbered free page as in use. From the next cycle, allocResult holds that page number in bits [6:0] with bit 7 clear, and intStatus bit 3 is set.
- R2: Starting from reset, consecutive allocation commands return page numbers 0, 1, 2 and 3 in that order.
- R3: memInfo bits [15:8] hold the number of free pages and bits [7:0] hold the total page count, 4. After the k-th successful allocation (k counted from 1), memInfo reads 0x0(4-k)04.
- R4: An allocation command while no page is free sets allocResult to 0x80 and leaves intStatus and memInfo unchanged.
- R5: intStatus bit 3 stays set until a write to the acknowledge port with data bit 3 equal to 1. An acknowledge write with bit 3 clear has no effect. When an acknowledge and a successful allocation arrive in the same cycle, the flag stays set.
- R6: A command write of 0x0040 frees every page and empties both queues. From the next cycle, memInfo reads 0x0404 and fifoPorts reads 0x8080.
- R7: fifoPorts layout: bit 15 is set when the receive queue is empty, and bits [14:8] hold its head number. Bit 7 is set when the transmit-completion queue is empty, and bits [6:0] hold its head number. The head field of an empty queue reads 0.
- R8: A command write of 0x0060 removes the head of the receive queue and leaves memInfo unchanged. After the last entry is removed, bit 15 of fifoPorts is set. The command has no effect on an empty queue.
- R9: Each queue accepts a push on a cycle where its valid input is high and keeps up to 4 entries in arrival order. A push into a full queue is dropped.
- R10: A command write whose code is not one of 0x0020, 0x0040 or 0x0060 leaves every output unchanged.
- R11: After hardware reset, memInfo reads 0x0404, fifoPorts reads 0x8080, allocResult reads 0x80 and intStatus reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrEn | input | 1 | Command write strobe |
| cmdCode | input | 16 | Command code |
| intAckWrEn | input | 1 | Interrupt acknowledge write strobe |
| intAckData | input | 8 | Acknowledge data; bit 3 clears the allocation flag |
| rxPushValid | input | 1 | Push a number into the receive queue |
| rxPushPkt | input | 2 | Packet number to push into the receive queue |
| txcPushValid | input | 1 | Push a number into the transmit-completion queue |
| txcPushPkt | input | 2 | Packet number to push into the transmit-completion queue |
| allocResult | output | 8 | Last allocation result; bit 7 flags failure |
| intStatus | output | 8 | Interrupt status; bit 3 is the allocation flag |
| memInfo | output | 16 | Free page count (high byte), total page count (low byte) |
| fifoPorts | output | 16 | Queue heads and empty flags |

## Verification
The hardest state to reach is a queue that has been filled to capacity, pushed once more, and then drained one entry at a time. The drop must not disturb the order that the drain reveals. The bench sweeps every fill level from one to four entries with rotating packet numbers, adds an overflow push on the full case, and checks every head value during the drain. It also exhausts the page pool, so that the failure byte, the untouched interrupt flag and a same-cycle acknowledge-versus-grant race can all be observed before a reset command restores the pool.

// File: rtl/pktMmuPkg.sv
package pktMmuPkg;
  localparam logic [15:0] CMD_ALLOC = 16'h0020;
  localparam logic [15:0] CMD_UNIT_RESET = 16'h0040;
  localparam logic [15:0] CMD_RX_POP = 16'h0060;
  localparam int INT_ALLOC_BIT = 3;
  localparam logic [7:0] RESULT_FAIL = 8'h80;

  typedef struct packed {
    logic allocReq;
    logic unitReset;
    logic rxPop;
    logic intClear;
  } mmuStrobe_t;
endpackage

// File: rtl/pktNumFifo.sv
module pktNumFifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic doPop, doPush;

  assign empty = (count == '0);
  assign full = (count == CW'(DEPTH));
  assign doPop = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head = empty ? '0 : store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPop) begin
        rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      if (doPush) begin
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPush && !doPop) begin
        count <= count + 1'b1;
      end else if (doPop && !doPush) begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) begin
      store[wrPtr] <= pushData;
    end
  end
endmodule

// File: rtl/pktMmuCtrl.sv
module pktMmuCtrl
  import pktMmuPkg::*;
(
  input  logic       cmdWrEn,
  input  logic [15:0] cmdCode,
  input  logic       intAckWrEn,
  input  logic [7:0] intAckData,
  output mmuStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (cmdWrEn) begin
      unique case (cmdCode)
        CMD_ALLOC:      strobe.allocReq = 1'b1;
        CMD_UNIT_RESET: strobe.unitReset = 1'b1;
        CMD_RX_POP:     strobe.rxPop = 1'b1;
        default:        ;
      endcase
    end
    strobe.intClear = intAckWrEn && intAckData[INT_ALLOC_BIT];
  end
endmodule

// File: rtl/pktMmuData.sv
module pktMmuData
  import pktMmuPkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int PNW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  mmuStrobe_t     strobe,
  input  logic           rxPushValid,
  input  logic [PNW-1:0] rxPushPkt,
  input  logic           txcPushValid,
  input  logic [PNW-1:0] txcPushPkt,
  output logic [7:0]     allocResult,
  output logic [7:0]     intStatus,
  output logic [15:0]    memInfo,
  output logic [15:0]    fifoPorts
);
  localparam logic [7:0] TOTAL_BYTE = 8'(NUM_PAGES);

  logic [NUM_PAGES-1:0] inUse;
  logic [PNW-1:0] pick;
  logic anyFree;
  logic [7:0] freeCount;
  logic intFlag;

  always_comb begin
    pick = '0;
    anyFree = 1'b0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!inUse[i]) begin
        pick = PNW'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    freeCount = '0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (!inUse[i]) freeCount = freeCount + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inUse <= '0;
      allocResult <= RESULT_FAIL;
      intFlag <= 1'b0;
    end else begin
      if (strobe.unitReset) begin
        inUse <= '0;
      end else if (strobe.allocReq && anyFree) begin
        inUse[pick] <= 1'b1;
      end
      if (strobe.allocReq) begin
        allocResult <= anyFree ? 8'(pick) : RESULT_FAIL;
      end
      if (strobe.allocReq && anyFree) begin
        intFlag <= 1'b1;
      end else if (strobe.intClear) begin
        intFlag <= 1'b0;
      end
    end
  end

  logic [PNW-1:0] rxHead, txcHead;
  logic rxEmpty, txcEmpty, rxFull, txcFull;

  pktNumFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PNW)) rxQ_i (
    .clk(clk), .rstN(rstN), .flush(strobe.unitReset),
    .push(rxPushValid), .pushData(rxPushPkt), .pop(strobe.rxPop),
    .head(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  pktNumFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PNW)) txcQ_i (
    .clk(clk), .rstN(rstN), .flush(strobe.unitReset),
    .push(txcPushValid), .pushData(txcPushPkt), .pop(1'b0),
    .head(txcHead), .empty(txcEmpty), .full(txcFull)
  );

  logic unusedFull;
  assign unusedFull = rxFull ^ txcFull;

  assign intStatus = 8'(intFlag) << INT_ALLOC_BIT;
  assign memInfo = {freeCount, TOTAL_BYTE};
  assign fifoPorts = {rxEmpty, 7'(rxHead), txcEmpty, 7'(txcHead)};
endmodule

// File: rtl/pktPageMmu.sv
module pktPageMmu
  import pktMmuPkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int PNW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdWrEn,
  input  logic [15:0]    cmdCode,
  input  logic           intAckWrEn,
  input  logic [7:0]     intAckData,
  input  logic           rxPushValid,
  input  logic [PNW-1:0] rxPushPkt,
  input  logic           txcPushValid,
  input  logic [PNW-1:0] txcPushPkt,
  output logic [7:0]     allocResult,
  output logic [7:0]     intStatus,
  output logic [15:0]    memInfo,
  output logic [15:0]    fifoPorts
);
  mmuStrobe_t strobe;

  pktMmuCtrl ctrl_i (
    .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
    .intAckWrEn(intAckWrEn), .intAckData(intAckData),
    .strobe(strobe)
  );

  pktMmuData #(.NUM_PAGES(NUM_PAGES), .FIFO_DEPTH(FIFO_DEPTH), .PNW(PNW)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxPushValid(rxPushValid), .rxPushPkt(rxPushPkt),
    .txcPushValid(txcPushValid), .txcPushPkt(txcPushPkt),
    .allocResult(allocResult), .intStatus(intStatus),
    .memInfo(memInfo), .fifoPorts(fifoPorts)
  );
endmodule

// File: rtl/pktPageMmuChk.sv
module pktPageMmuChk #(
  parameter int NUM_PAGES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrEn,
  input logic [15:0] cmdCode,
  input logic        intAckWrEn,
  input logic        rxPushValid,
  input logic        txcPushValid,
  input logic [7:0]  allocResult,
  input logic [7:0]  intStatus,
  input logic [15:0] memInfo,
  input logic [15:0] fifoPorts
);
  localparam logic [7:0] TOT = 8'(NUM_PAGES);

  logic isAlloc, isReset, isPop, isKnown, quiet;
  assign isAlloc = cmdWrEn && (cmdCode == 16'h0020);
  assign isReset = cmdWrEn && (cmdCode == 16'h0040);
  assign isPop = cmdWrEn && (cmdCode == 16'h0060);
  assign isKnown = isAlloc || isReset || isPop;
  assign quiet = !intAckWrEn && !rxPushValid && !txcPushValid;

  // R1
  alloc_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAlloc && memInfo[15:8] != 8'd0) |=>
      (intStatus[3] && !allocResult[7] && memInfo[15:8] == $past(memInfo[15:8]) - 8'd1));

  // R4
  alloc_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAlloc && memInfo[15:8] == 8'd0 && !intAckWrEn) |=>
      (allocResult == 8'h80 && $stable(intStatus) && $stable(memInfo)));

  // R3
  total_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memInfo[7:0] == TOT && memInfo[15:8] <= TOT));

  // R6
  unit_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    isReset |=> (memInfo == {TOT, TOT} && fifoPorts == 16'h8080));

  // R8
  pop_keeps_pages_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPop |=> $stable(memInfo));

  // R10
  unknown_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !isKnown && quiet) |=>
      ($stable(memInfo) && $stable(fifoPorts) && $stable(allocResult) && $stable(intStatus)));

  // R7
  empty_head_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!fifoPorts[15] || fifoPorts[14:8] == 7'd0) && (!fifoPorts[7] || fifoPorts[6:0] == 7'd0)));
endmodule

bind pktPageMmu pktPageMmuChk #(.NUM_PAGES(NUM_PAGES)) chk_i (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
  .intAckWrEn(intAckWrEn), .rxPushValid(rxPushValid), .txcPushValid(txcPushValid),
  .allocResult(allocResult), .intStatus(intStatus),
  .memInfo(memInfo), .fifoPorts(fifoPorts)
);

// File: tb/pktPageMmu_tb.sv
module pktPageMmu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [15:0] cmdCode = '0;
  logic intAckWrEn = 1'b0;
  logic [7:0] intAckData = '0;
  logic rxPushValid = 1'b0;
  logic [1:0] rxPushPkt = '0;
  logic txcPushValid = 1'b0;
  logic [1:0] txcPushPkt = '0;
  logic [7:0] allocResult, intStatus;
  logic [15:0] memInfo, fifoPorts;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pktPageMmu dut_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
    .intAckWrEn(intAckWrEn), .intAckData(intAckData),
    .rxPushValid(rxPushValid), .rxPushPkt(rxPushPkt),
    .txcPushValid(txcPushValid), .txcPushPkt(txcPushPkt),
    .allocResult(allocResult), .intStatus(intStatus),
    .memInfo(memInfo), .fifoPorts(fifoPorts)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmdWrEn = 1'b0; intAckWrEn = 1'b0; rxPushValid = 1'b0; txcPushValid = 1'b0;
  endtask

  task automatic cmd(input logic [15:0] code);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdCode = code;
    step();
  endtask

  task automatic ack(input logic [7:0] d);
    @(negedge clk);
    intAckWrEn = 1'b1; intAckData = d;
    step();
  endtask

  task automatic pushRx(input logic [1:0] v);
    @(negedge clk);
    rxPushValid = 1'b1; rxPushPkt = v;
    step();
  endtask

  task automatic pushTxc(input logic [1:0] v);
    @(negedge clk);
    txcPushValid = 1'b1; txcPushPkt = v;
    step();
  endtask

  function automatic logic [15:0] ports(input bit rxE, input int rxH, input bit txE, input int txH);
    return {rxE, 7'(rxH), txE, 7'(txH)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 memInfo", memInfo, 16'h0404);
    chk("R11 fifoPorts", fifoPorts, 16'h8080);
    chk("R11 allocResult", {8'h0, allocResult}, 16'h0080);
    chk("R11 intStatus", {8'h0, intStatus}, 16'h0000);

    // R1 R2 R3 ascending allocation, two full rounds via unit reset
    for (int round = 0; round < 2; round++) begin
      for (int i = 0; i < 4; i++) begin
        cmd(16'h0020);
        chk("R2 result", {8'h0, allocResult}, 16'(i));
        chk("R1 int", {8'h0, intStatus}, 16'h0008);
        chk("R3 memInfo", memInfo, 16'(((3 - i) << 8) | 4));
        ack(8'h08);
        chk("R5 ack clears", {8'h0, intStatus}, 16'h0000);
      end
      // R4 exhausted pool
      cmd(16'h0020);
      chk("R4 fail result", {8'h0, allocResult}, 16'h0080);
      chk("R4 int unchanged", {8'h0, intStatus}, 16'h0000);
      chk("R4 memInfo unchanged", memInfo, 16'h0004);
      cmd(16'h0040);
      chk("R6 memInfo", memInfo, 16'h0404);
      chk("R6 fifoPorts", fifoPorts, 16'h8080);
    end

    // R5 flag persistence and ack behaviour
    cmd(16'h0020);
    ack(8'hF7);
    chk("R5 ack without bit3", {8'h0, intStatus}, 16'h0008);
    repeat (3) step();
    chk("R5 flag holds", {8'h0, intStatus}, 16'h0008);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdCode = 16'h0020; intAckWrEn = 1'b1; intAckData = 8'h08;
    step();
    chk("R5 grant beats ack", {8'h0, intStatus}, 16'h0008);
    chk("R1 lowest free", {8'h0, allocResult}, 16'h0001);
    ack(8'h08);
    chk("R5 cleared", {8'h0, intStatus}, 16'h0000);
    cmd(16'h0040);

    // R7 R8 R9 receive queue at every fill level, overflow on full
    for (int n = 1; n <= 4; n++) begin
      for (int j = 0; j < n; j++) pushRx(2'((n + j) % 4));
      if (n == 4) begin
        pushRx(2'(n + 3));
        // R9 overflow dropped, head unchanged
        chk("R9 full push dropped", fifoPorts, ports(0, n % 4, 1, 0));
      end
      for (int j = 0; j < n; j++) begin
        chk("R7 rx head", fifoPorts, ports(0, (n + j) % 4, 1, 0));
        cmd(16'h0060);
        chk("R8 pop keeps memInfo", memInfo, 16'h0404);
      end
      chk("R8 empty after drain", fifoPorts, 16'h8080);
    end
    cmd(16'h0060);
    chk("R8 pop on empty", fifoPorts, 16'h8080);

    // R9 R7 transmit-completion queue
    for (int j = 0; j < 4; j++) pushTxc(2'(3 - j));
    pushTxc(2'd0);
    chk("R9 txc head", fifoPorts, ports(1, 0, 0, 3));
    cmd(16'h0060);
    chk("R8 pop leaves txc", fifoPorts, ports(1, 0, 0, 3));
    cmd(16'h0040);
    chk("R6 txc flushed", fifoPorts, 16'h8080);

    // R10 unknown codes with nontrivial state
    cmd(16'h0020);
    cmd(16'h0020);
    pushRx(2'd2);
    pushTxc(2'd1);
    for (int c = 0; c < 512; c++) begin
      if (c == 16'h20 || c == 16'h40 || c == 16'h60) continue;
      cmd(16'(c));
      chk("R10 memInfo", memInfo, 16'h0204);
      chk("R10 fifoPorts", fifoPorts, ports(0, 2, 0, 1));
      chk("R10 result", {8'h0, allocResult}, 16'h0001);
      chk("R10 int", {8'h0, intStatus}, 16'h0008);
    end
    cmd(16'h8020);
    chk("R10 high bits", memInfo, 16'h0204);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule